// File: doc/BRIEF.md
# Three-Pulse Request/Grant Bus Arbiter

This block hands the local bus over to one of up to two alternate masters. Each master shares a single active-low line with the block, which is modelled here as a separate sampled input and a driven output per channel. One exchange on a channel takes three one-clock low pulses. The master first requests the bus. The arbiter then grants it. Later the master gives the bus back with a release pulse.

The arbiter watches the state of the bus cycle that is running and picks a safe clock for the handover. The inputs it uses are the cycle phase, an active lock, the first interrupt-acknowledge cycle, and the first half of a word split across an odd address. While another master owns the bus, the arbiter raises `float_bus` so that the cycle engine tri-states its drivers. It also raises `hold_active` so that the sequencer stalls any new cycle.

Top module: `rg_arbiter`

## Requirements
- R1: While reset is asserted and straight after it, both grant lines are high, `float_bus` is 0 and `hold_active` is 0.
- R2: A request made while no bus cycle is running (`cyc_active`=0) produces a grant on the requesting channel one clock later. The grant is a single-clock low pulse, and `float_bus` is 1 from the following clock.
- R3: During a running cycle, the grant falls only in T4. The `tstate` encoding is 0=T1, 1=T2, 2=T3/TW and 3=T4. A request first seen in T3 or T4 is not granted in that cycle and waits for the T4 of the next cycle.
- R4: No grant is given in a T4 while `odd_split` or `inta_first` is 1. The request stays pending for a later cycle.
- R5: No grant is given while `lock_active` is 1. A request seen during a lock is kept and is granted once the lock drops.
- R6: When both channels request in the same clock, channel 0 (bit 0) is granted first. Channel 1 is granted after channel 0 releases the bus. At most one grant line is low at a time.
- R7: A low pulse from the owning channel during hold is its release. `float_bus` and `hold_active` fall in the clock after that pulse.
- R8: After a release there is one dead clock with no grant, even if a request is pending. The earliest new grant comes two clocks after the release pulse.
- R9: `hold_active` is 1 during the grant pulse and during every clock in which `float_bus` is 1.
- R10: A pulse from the channel that does not own the bus, sent during hold, does not release the bus. It is recorded as a request for later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_n_in | input | NCH | Sampled request/release pulses, active low, bit 0 = channel 0 |
| gnt_n_out | output | NCH | Grant pulses, active low |
| cyc_active | input | 1 | A bus cycle is running |
| tstate | input | 2 | Phase of running cycle: 0 T1, 1 T2, 2 T3/TW, 3 T4 |
| lock_active | input | 1 | Locked instruction executing |
| inta_first | input | 1 | Current cycle is the first interrupt acknowledge |
| odd_split | input | 1 | Current cycle is the first half of an odd-address word |
| float_bus | output | 1 | Bus is released to another master |
| hold_active | output | 1 | Stall new bus cycles |

## Verification
On every clock the assertions check these properties:
- At most one grant line is low, and it is low for only one clock.
- No grant is given under a lock, an odd-word split or the first interrupt acknowledge, and a grant during a running cycle comes only in T4.
- A grant is followed by float, and `hold_active` is high whenever the bus floats.
- Float drops right after a release, followed by a grant-free clock.

Other behaviours need the bench's scenarios, because they span many clocks and depend on earlier stimulus:
- a late request being carried over to the next cycle
- a request made under a lock being honoured after the lock drops
- channel 1 being served after channel 0
- a pulse from the non-owner being stored rather than taken as a release

// File: rtl/rg_arbiter.sv
module rg_arbiter #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req_n_in,
  output logic [NCH-1:0] gnt_n_out,
  input  logic           cyc_active,
  input  logic [1:0]     tstate,
  input  logic           lock_active,
  input  logic           inta_first,
  input  logic           odd_split,
  output logic           float_bus,
  output logic           hold_active
);
  localparam logic [1:0] T_T1 = 2'd0;
  localparam logic [1:0] T_T2 = 2'd1;
  localparam logic [1:0] T_T4 = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_HOLD, S_DEAD} st_t;

  st_t            st;
  logic [NCH-1:0] req, pend, pick, own, rec;
  logic           early, cond_ok, fire, rel;

  assign req = ~req_n_in;

  always_comb begin
    pick = '0;
    for (int i = NCH-1; i >= 0; i--)
      if (pend[i]) pick = NCH'(1) << i;
  end

  assign cond_ok = !lock_active &&
                   (!cyc_active || (tstate == T_T4 && early && !inta_first && !odd_split));
  assign fire    = (st == S_IDLE) && (|pend) && cond_ok;
  assign rel     = (st == S_HOLD) && (|(req & own));
  assign rec     = req & ~((st == S_HOLD) ? own : '0);

  assign gnt_n_out   = ~(fire ? pick : '0);
  assign float_bus   = (st == S_HOLD);
  assign hold_active = fire || (st == S_HOLD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      pend  <= '0;
      own   <= '0;
      early <= 1'b0;
    end else begin
      pend  <= (pend & ~(fire ? pick : '0)) | rec;
      early <= !fire && (|(pend | rec)) &&
               (early || !cyc_active || tstate == T_T1 || tstate == T_T2);
      case (st)
        S_IDLE: if (fire) begin st <= S_HOLD; own <= pick; end
        S_HOLD: if (rel) st <= S_DEAD;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_GNT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~gnt_n_out)); // R6
  AST_GNT_THEN_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_n_out != '1) |=> (float_bus && gnt_n_out == '1)); // R2
  AST_ACTIVE_GNT_T4: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_n_out != '1 && cyc_active) |-> (tstate == T_T4)); // R3
  AST_NO_GNT_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_n_out != '1 && cyc_active) |-> (!odd_split && !inta_first)); // R4
  AST_NO_GNT_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_n_out != '1) |-> !lock_active); // R5
  AST_RELEASE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (float_bus && |(req & own)) |=> (!float_bus && !hold_active)); // R7
  AST_DEAD_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(float_bus) |-> (gnt_n_out == '1)); // R8
  AST_HOLD_COVER: assert property (@(posedge clk) disable iff (!rst_n)
    float_bus |-> hold_active); // R9
endmodule

// File: tb/rg_arbiter_tb.sv
module rg_arbiter_tb;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [1:0] req_n_in = 2'b11;
  logic [1:0] gnt_n_out;
  logic       cyc_active = 0;
  logic [1:0] tstate = 0;
  logic       lock_active = 0, inta_first = 0, odd_split = 0;
  logic       float_bus, hold_active;

  typedef struct {
    logic [1:0] gnt;
    logic       flt;
    logic       hld;
    string      tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rg_arbiter #(.NCH(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_n_in(req_n_in), .gnt_n_out(gnt_n_out),
    .cyc_active(cyc_active), .tstate(tstate), .lock_active(lock_active),
    .inta_first(inta_first), .odd_split(odd_split),
    .float_bus(float_bus), .hold_active(hold_active));

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (gnt_n_out !== e.gnt || float_bus !== e.flt || hold_active !== e.hld) begin
        errors++;
        $display("FAIL %s: got gnt=%b float=%b hold=%b, expected gnt=%b float=%b hold=%b",
                 e.tag, gnt_n_out, float_bus, hold_active, e.gnt, e.flt, e.hld);
      end
    end
  end

  task automatic step(input logic [1:0] rq, input logic act, input logic [1:0] ts,
                      input logic lk, input logic ia, input logic od,
                      input logic [1:0] eg, input logic ef, input logic eh, input string tag);
    exp_t e;
    @(posedge clk); #1;
    req_n_in = rq; cyc_active = act; tstate = ts;
    lock_active = lk; inta_first = ia; odd_split = od;
    e.gnt = eg; e.flt = ef; e.hld = eh; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idl(input logic [1:0] rq, input logic [1:0] eg, input logic ef,
                     input logic eh, input string tag);
    step(rq, 0, 0, 0, 0, 0, eg, ef, eh, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (gnt_n_out !== 2'b11 || float_bus !== 0 || hold_active !== 0) begin
      errors++;
      $display("FAIL R1: got gnt=%b float=%b hold=%b, expected 11 0 0", gnt_n_out, float_bus, hold_active);
    end
    rst_n = 1;
    idl(2'b11, 2'b11, 0, 0, "R1 after reset");

    idl(2'b10, 2'b11, 0, 0, "R2 request cycle");
    idl(2'b11, 2'b10, 0, 1, "R2 R9 idle grant ch0");
    idl(2'b11, 2'b11, 1, 1, "R2 float after grant");
    idl(2'b10, 2'b11, 1, 1, "R7 release cycle");
    idl(2'b11, 2'b11, 0, 0, "R7 float drops");
    idl(2'b11, 2'b11, 0, 0, "R7 idle");

    idl(2'b10, 2'b11, 0, 0, "R10 request ch0");
    idl(2'b11, 2'b10, 0, 1, "R10 grant ch0");
    idl(2'b01, 2'b11, 1, 1, "R10 ch1 pulse in hold");
    idl(2'b11, 2'b11, 1, 1, "R10 bus not released");
    idl(2'b10, 2'b11, 1, 1, "R10 ch0 release");
    idl(2'b11, 2'b11, 0, 0, "R8 dead clock");
    idl(2'b11, 2'b01, 0, 1, "R10 stored ch1 granted");
    idl(2'b11, 2'b11, 1, 1, "R10 ch1 hold");
    idl(2'b01, 2'b11, 1, 1, "R7 ch1 release");
    idl(2'b11, 2'b11, 0, 0, "R8 dead");
    idl(2'b11, 2'b11, 0, 0, "R8 idle");

    idl(2'b00, 2'b11, 0, 0, "R6 both request");
    idl(2'b11, 2'b10, 0, 1, "R6 ch0 first");
    idl(2'b11, 2'b11, 1, 1, "R6 hold ch0");
    idl(2'b10, 2'b11, 1, 1, "R6 release ch0");
    idl(2'b11, 2'b11, 0, 0, "R8 dead before ch1");
    idl(2'b11, 2'b01, 0, 1, "R6 ch1 second");
    idl(2'b11, 2'b11, 1, 1, "R6 hold ch1");
    idl(2'b01, 2'b11, 1, 1, "R6 release ch1");
    idl(2'b11, 2'b11, 0, 0, "R6 dead");

    step(2'b11, 1, 0, 0, 0, 0, 2'b11, 0, 0, "R3 T1");
    step(2'b10, 1, 1, 0, 0, 0, 2'b11, 0, 0, "R3 request at T2");
    step(2'b11, 1, 2, 0, 0, 0, 2'b11, 0, 0, "R3 no grant T3");
    step(2'b11, 1, 3, 0, 0, 0, 2'b10, 0, 1, "R3 grant at T4");
    idl(2'b11, 2'b11, 1, 1, "R3 float");
    idl(2'b10, 2'b11, 1, 1, "R3 release");
    idl(2'b11, 2'b11, 0, 0, "R3 dead");

    step(2'b11, 1, 0, 0, 0, 0, 2'b11, 0, 0, "R3 late T1");
    step(2'b11, 1, 1, 0, 0, 0, 2'b11, 0, 0, "R3 late T2");
    step(2'b01, 1, 2, 0, 0, 0, 2'b11, 0, 0, "R3 request at T3");
    step(2'b11, 1, 3, 0, 0, 0, 2'b11, 0, 0, "R3 late request not granted T4");
    step(2'b11, 1, 0, 0, 0, 0, 2'b11, 0, 0, "R3 next T1");
    step(2'b11, 1, 1, 0, 0, 0, 2'b11, 0, 0, "R3 next T2");
    step(2'b11, 1, 2, 0, 0, 0, 2'b11, 0, 0, "R3 next T3");
    step(2'b11, 1, 3, 0, 0, 0, 2'b01, 0, 1, "R3 granted next T4");
    idl(2'b11, 2'b11, 1, 1, "R3 float ch1");
    idl(2'b01, 2'b11, 1, 1, "R3 release ch1");
    idl(2'b11, 2'b11, 0, 0, "R3 dead ch1");

    step(2'b10, 1, 0, 0, 0, 0, 2'b11, 0, 0, "R4 request T1");
    step(2'b11, 1, 1, 0, 0, 1, 2'b11, 0, 0, "R4 split T2");
    step(2'b11, 1, 2, 0, 0, 1, 2'b11, 0, 0, "R4 split T3");
    step(2'b11, 1, 3, 0, 0, 1, 2'b11, 0, 0, "R4 no grant odd split T4");
    step(2'b11, 1, 0, 0, 1, 0, 2'b11, 0, 0, "R4 inta T1");
    step(2'b11, 1, 1, 0, 1, 0, 2'b11, 0, 0, "R4 inta T2");
    step(2'b11, 1, 2, 0, 1, 0, 2'b11, 0, 0, "R4 inta T3");
    step(2'b11, 1, 3, 0, 1, 0, 2'b11, 0, 0, "R4 no grant first inta T4");
    step(2'b11, 1, 0, 0, 0, 0, 2'b11, 0, 0, "R4 plain T1");
    step(2'b11, 1, 1, 0, 0, 0, 2'b11, 0, 0, "R4 plain T2");
    step(2'b11, 1, 2, 0, 0, 0, 2'b11, 0, 0, "R4 plain T3");
    step(2'b11, 1, 3, 0, 0, 0, 2'b10, 0, 1, "R4 granted plain T4");
    idl(2'b11, 2'b11, 1, 1, "R4 float");
    idl(2'b10, 2'b11, 1, 1, "R4 release");
    idl(2'b11, 2'b11, 0, 0, "R4 dead");

    step(2'b01, 0, 0, 1, 0, 0, 2'b11, 0, 0, "R5 request under lock");
    step(2'b11, 0, 0, 1, 0, 0, 2'b11, 0, 0, "R5 held by lock a");
    step(2'b11, 0, 0, 1, 0, 0, 2'b11, 0, 0, "R5 held by lock b");
    step(2'b11, 0, 0, 0, 0, 0, 2'b01, 0, 1, "R5 granted when lock ends");
    idl(2'b11, 2'b11, 1, 1, "R5 float");
    idl(2'b01, 2'b11, 1, 1, "R5 release");
    idl(2'b11, 2'b11, 0, 0, "R5 dead");

    @(posedge clk); @(posedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #40000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule